// File: doc/BRIEF.md
# Real-Time Seconds Counter with Alarm

This block is a real-time clock core for a simple register bus. A 32-bit seconds count advances once for every `PRESCALE` pulses of a slow-clock strobe, which is nominally a 32.768 kHz edge marker retimed into the bus clock. A 32-bit alarm value is compared against each new count. Two sticky event flags record second increments and alarm matches. Each flag has its own interrupt enable, and the two masked flags are OR-ed into one registered interrupt line. A scratchpad register holds software state across resets of the rest of the system.

Register writes pass through a gate. An accepted write drops the write-ready bit for `WR_HOLD` slow-clock strobes, which models the transfer into the slow domain. A write issued while ready is low is dropped. When `UNLOCK_EN` is set, each data register write must be preceded by a key write to the unlock register. One key write admits exactly one data write. Reads return registered data one bus cycle after the read strobe, so the seconds value read is always a complete register value.

Top module: `rtc_sec_alarm`

## Requirements
- R1: After reset, the seconds, alarm and scratchpad registers read 0, the control register reads 0x80 (write-ready set, all else clear) and `irq_o` is low.
- R2: Registers sit at control 0x00, seconds 0x04, alarm 0x08, scratchpad 0x34 and unlock 0x3C. A read strobe in cycle n returns data on `rdata_o` after edge n. Unmapped addresses read 0.
- R3: While control bit 0 is 1, the seconds count increments on every `PRESCALE`-th slow strobe and wraps from 0xFFFFFFFF to 0. While bit 0 is 0, the count holds and the prescaler restarts from zero.
- R4: Control bit 7 (write-ready, read-only) goes to 0 for `WR_HOLD` slow strobes after each accepted write. A data write issued while it is 0 is ignored and does not consume the unlock.
- R5: Writing exactly 0x0000A55A to 0x3C sets unlock bit 31. Exactly one following accepted data write clears it. Data writes made without the unlock are ignored. Unlock register writes are not gated by write-ready.
- R6: The 1 Hz flag (control bit 6) is set on every increment. The alarm flag (bit 4) is set when an increment makes the count equal the alarm value while alarm enable (bit 2) is 1.
- R7: A flag is cleared only by an accepted control write with 0 in its bit. Writing 1 leaves it unchanged. A same-cycle set wins over a clear.
- R8: `irq_o` equals, one cycle later, (bit 6 AND bit 5 interrupt enable) OR (bit 4 AND bit 3 interrupt enable).
- R9: Two consecutive reads of the seconds register with no increment between them return the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| slow_tick_i | input | 1 | One-cycle strobe per slow-clock edge |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Registered interrupt request |

## Verification
On every cycle, the assertions check that the count moves only on an increment or an accepted write, the wrap to zero, that no increment occurs while the counter is disabled, that write-ready drops after an accepted write and rises only on a slow strobe, that the unlock is consumed, that flags stay set until explicitly cleared, and the interrupt timing. Only the bench's scenarios show the one-key-one-write rule, writes rejected while busy, clearing one flag while the other survives, and the stability of back-to-back reads. The bench shows these by comparing every cycle against a behavioural model and by reading back registers after each stimulus.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int AW = 8;
  localparam int DW = 32;

  localparam logic [AW-1:0] A_CTRL = 8'h00;
  localparam logic [AW-1:0] A_SEC  = 8'h04;
  localparam logic [AW-1:0] A_ALM  = 8'h08;
  localparam logic [AW-1:0] A_SCR  = 8'h34;
  localparam logic [AW-1:0] A_KEY  = 8'h3C;

  localparam int B_EN  = 0;
  localparam int B_AEN = 2;
  localparam int B_AIE = 3;
  localparam int B_AF  = 4;
  localparam int B_HIE = 5;
  localparam int B_HF  = 6;
  localparam int B_RDY = 7;

  function automatic logic is_data_reg(input logic [AW-1:0] a);
    return (a == A_CTRL) || (a == A_SEC) || (a == A_ALM) || (a == A_SCR);
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int PRESCALE = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic slow_tick_i,
  output logic sec_tick_o
);
  localparam int PW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] cnt_q;

  assign sec_tick_o = run_i && slow_tick_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (!run_i)       cnt_q <= '0;
    else if (slow_tick_i)  cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assert_no_tick_when_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slow_tick_i |-> !sec_tick_o);
endmodule

// File: rtl/rtc_wr_gate.sv
module rtc_wr_gate
  import rtc_pkg::*;
#(
  parameter int          WR_HOLD   = 3,
  parameter bit          UNLOCK_EN = 1'b1,
  parameter logic [15:0] KEY       = 16'hA55A
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          slow_tick_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          wr_rdy_o,
  output logic          unlocked_o,
  output logic          accept_o
);
  localparam int BW = $clog2(WR_HOLD + 1);
  localparam logic [BW-1:0] HOLD = BW'(WR_HOLD);

  logic [BW-1:0] busy_q;

  assign wr_rdy_o = (busy_q == '0);
  assign accept_o = wr_en_i && wr_rdy_o && unlocked_o && is_data_reg(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      busy_q <= '0;
    else if (accept_o)                busy_q <= HOLD;
    else if (slow_tick_i && !wr_rdy_o) busy_q <= busy_q - 1'b1;
  end

  generate
    if (UNLOCK_EN) begin : g_key
      logic unl_q;
      logic key_hit;
      assign key_hit    = wr_en_i && (addr_i == A_KEY) && (wdata_i == {16'h0, KEY});
      assign unlocked_o = unl_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       unl_q <= 1'b0;
        else if (accept_o) unl_q <= 1'b0;
        else if (key_hit)  unl_q <= 1'b1;
      end
      assert_unlock_consumed_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        accept_o |=> !unlocked_o);
    end else begin : g_nokey
      assign unlocked_o = 1'b1;
    end
  endgenerate

  assert_busy_after_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> !wr_rdy_o);
  assert_ready_on_slow_edge_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_rdy_o) |-> $past(slow_tick_i));
endmodule

// File: rtl/rtc_events.sv
module rtc_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sec_tick_i,
  input  logic alarm_hit_i,
  input  logic ctrl_wr_i,
  input  logic hz_keep_i,
  input  logic al_keep_i,
  input  logic hz_ie_i,
  input  logic al_ie_i,
  output logic hz_flag_o,
  output logic al_flag_o,
  output logic irq_o
);
  logic hz_clr, al_clr;

  assign hz_clr = ctrl_wr_i && !hz_keep_i;
  assign al_clr = ctrl_wr_i && !al_keep_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hz_flag_o <= 1'b0;
      al_flag_o <= 1'b0;
      irq_o     <= 1'b0;
    end else begin
      hz_flag_o <= (hz_flag_o && !hz_clr) || sec_tick_i;
      al_flag_o <= (al_flag_o && !al_clr) || alarm_hit_i;
      irq_o     <= (hz_flag_o && hz_ie_i) || (al_flag_o && al_ie_i);
    end
  end

  assert_hz_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_tick_i |=> hz_flag_o);
  assert_al_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_hit_i |=> al_flag_o);
  assert_hz_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hz_flag_o && !ctrl_wr_i) |=> hz_flag_o);
  assert_al_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (al_flag_o && !ctrl_wr_i) |=> al_flag_o);
  assert_irq_follows_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((hz_flag_o && hz_ie_i) || (al_flag_o && al_ie_i)) |=> irq_o);
endmodule

// File: rtl/rtc_sec_alarm.sv
module rtc_sec_alarm
  import rtc_pkg::*;
#(
  parameter int          PRESCALE  = 32768,
  parameter int          WR_HOLD   = 3,
  parameter bit          UNLOCK_EN = 1'b1,
  parameter logic [15:0] KEY       = 16'hA55A
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        slow_tick_i,
  input  logic        wr_en_i,
  input  logic        rd_en_i,
  input  logic [7:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        irq_o
);
  logic          en_q, al_en_q, al_ie_q, hz_ie_q;
  logic [DW-1:0] sec_q, alm_q, scr_q;
  logic          wr_rdy, unlocked, accept;
  logic          sec_tick, alarm_hit, hz_flag, al_flag;
  logic          wr_ctrl, wr_sec, wr_alm, wr_scr;

  rtc_wr_gate #(.WR_HOLD(WR_HOLD), .UNLOCK_EN(UNLOCK_EN), .KEY(KEY)) u_gate (
    .clk_i, .rst_ni, .slow_tick_i, .wr_en_i, .addr_i, .wdata_i,
    .wr_rdy_o(wr_rdy), .unlocked_o(unlocked), .accept_o(accept)
  );

  rtc_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk_i, .rst_ni, .run_i(en_q), .slow_tick_i, .sec_tick_o(sec_tick)
  );

  assign wr_ctrl   = accept && (addr_i == A_CTRL);
  assign wr_sec    = accept && (addr_i == A_SEC);
  assign wr_alm    = accept && (addr_i == A_ALM);
  assign wr_scr    = accept && (addr_i == A_SCR);
  // match is judged on the value the increment produces
  assign alarm_hit = sec_tick && al_en_q && ((sec_q + 32'd1) == alm_q);

  rtc_events u_evt (
    .clk_i, .rst_ni, .sec_tick_i(sec_tick), .alarm_hit_i(alarm_hit),
    .ctrl_wr_i(wr_ctrl), .hz_keep_i(wdata_i[B_HF]), .al_keep_i(wdata_i[B_AF]),
    .hz_ie_i(hz_ie_q), .al_ie_i(al_ie_q),
    .hz_flag_o(hz_flag), .al_flag_o(al_flag), .irq_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0; al_en_q <= 1'b0; al_ie_q <= 1'b0; hz_ie_q <= 1'b0;
      sec_q <= '0; alm_q <= '0; scr_q <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q    <= wdata_i[B_EN];
        al_en_q <= wdata_i[B_AEN];
        al_ie_q <= wdata_i[B_AIE];
        hz_ie_q <= wdata_i[B_HIE];
      end
      if (wr_sec)        sec_q <= wdata_i;
      else if (sec_tick) sec_q <= sec_q + 32'd1;
      if (wr_alm) alm_q <= wdata_i;
      if (wr_scr) scr_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else if (rd_en_i) begin
      unique case (addr_i)
        A_CTRL:  rdata_o <= {24'h0, wr_rdy, hz_flag, hz_ie_q, al_flag,
                             al_ie_q, al_en_q, 1'b0, en_q};
        A_SEC:   rdata_o <= sec_q;
        A_ALM:   rdata_o <= alm_q;
        A_SCR:   rdata_o <= scr_q;
        A_KEY:   rdata_o <= {unlocked, 31'h0};
        default: rdata_o <= '0;
      endcase
    end
  end

  assert_sec_holds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sec_tick && !wr_sec) |=> $stable(sec_q));
  assert_sec_wraps_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_tick && !wr_sec && (sec_q == 32'hFFFF_FFFF)) |=> (sec_q == 32'h0));
  assert_no_count_disabled_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> !sec_tick);
endmodule

// File: tb/rtc_sec_alarm_bench.sv
module rtc_sec_alarm_bench;
  localparam int P    = 4;
  localparam int HOLD = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rtc_sec_alarm #(.PRESCALE(P), .WR_HOLD(HOLD), .UNLOCK_EN(1'b1), .KEY(16'hA55A)) u_rtc_sec_alarm (
    .clk_i(clk), .rst_ni(rst_n), .slow_tick_i(slow), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  // behavioural reference
  logic        m_en, m_alen, m_alie, m_hzie, m_hzf, m_alf, m_unl, m_irq;
  logic [31:0] m_sec, m_alarm, m_scr, m_rdata;
  int          m_busy, m_pre;

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h00: return {24'h0, (m_busy == 0), m_hzf, m_hzie, m_alf, m_alie, m_alen, 1'b0, m_en};
      8'h04: return m_sec;
      8'h08: return m_alarm;
      8'h34: return m_scr;
      8'h3C: return {m_unl, 31'h0};
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_alen = 0; m_alie = 0; m_hzie = 0; m_hzf = 0; m_alf = 0;
      m_unl = 0; m_irq = 0; m_sec = 0; m_alarm = 0; m_scr = 0; m_rdata = 0;
      m_busy = 0; m_pre = 0;
    end else begin
      bit dhit, acc, tick, alset;
      dhit  = (addr == 8'h00) || (addr == 8'h04) || (addr == 8'h08) || (addr == 8'h34);
      acc   = wr_en && (m_busy == 0) && m_unl && dhit;
      tick  = m_en && slow && (m_pre == P - 1);
      alset = tick && m_alen && ((m_sec + 32'd1) == m_alarm);
      if (rd_en) m_rdata = m_read(addr);
      m_irq = (m_hzf && m_hzie) || (m_alf && m_alie);
      m_hzf = (m_hzf && !(acc && addr == 8'h00 && !wdata[6])) || tick;
      m_alf = (m_alf && !(acc && addr == 8'h00 && !wdata[4])) || alset;
      if (!m_en) m_pre = 0;
      else if (slow) m_pre = (m_pre == P - 1) ? 0 : m_pre + 1;
      if (acc && addr == 8'h04) m_sec = wdata;
      else if (tick) m_sec = m_sec + 32'd1;
      if (acc && addr == 8'h00) begin
        m_en = wdata[0]; m_alen = wdata[2]; m_alie = wdata[3]; m_hzie = wdata[5];
      end
      if (acc && addr == 8'h08) m_alarm = wdata;
      if (acc && addr == 8'h34) m_scr = wdata;
      if (acc) m_unl = 0;
      else if (wr_en && addr == 8'h3C && wdata == 32'h0000A55A) m_unl = 1;
      if (acc) m_busy = HOLD;
      else if (slow && m_busy != 0) m_busy = m_busy - 1;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (rdata_o !== m_rdata) begin
        errors++;
        $display("FAIL R2 rdata per-cycle: actual %h expected %h", rdata_o, m_rdata);
      end
      checks++;
      if (irq_o !== m_irq) begin
        errors++;
        $display("FAIL R8 irq per-cycle: actual %b expected %b", irq_o, m_irq);
      end
    end
  end

  initial begin
    forever begin
      repeat (2) @(negedge clk);
      slow = 1'b1;
      @(negedge clk);
      slow = 1'b0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata_o;
  endtask

  task automatic wait_rdy();
    while (m_busy != 0) @(negedge clk);
  endtask

  task automatic uwr(input logic [7:0] a, input logic [31:0] d);
    wait_rdy();
    bus_wr(8'h3C, 32'h0000A55A);
    bus_wr(a, d);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d, d2;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    bus_rd(8'h00, d); chk("R1 ctrl reset", d, 32'h80);
    bus_rd(8'h04, d); chk("R1 sec reset", d, 32'h0);
    bus_rd(8'h08, d); chk("R1 alarm reset", d, 32'h0);
    bus_rd(8'h34, d); chk("R1 scratch reset", d, 32'h0);
    chk("R1 irq reset", {31'h0, irq_o}, 32'h0);

    bus_wr(8'h34, 32'h11);
    bus_rd(8'h34, d); chk("R5 write without key ignored", d, 32'h0);
    bus_wr(8'h3C, 32'h0000A55B);
    bus_rd(8'h3C, d); chk("R5 wrong key rejected", d, 32'h0);
    bus_wr(8'h3C, 32'h0000A55A);
    bus_rd(8'h3C, d); chk("R5 key sets bit31", d, 32'h8000_0000);

    bus_wr(8'h34, 32'h1234_5678);
    bus_wr(8'h3C, 32'h0000A55A);
    bus_wr(8'h34, 32'h0000_DEAD);
    bus_rd(8'h34, d); chk("R4 write while busy ignored", d, 32'h1234_5678);
    bus_rd(8'h3C, d); chk("R4 rejected write keeps key", d, 32'h8000_0000);
    wait_rdy();
    bus_wr(8'h34, 32'h0000_CAFE);
    bus_rd(8'h00, d); chk("R4 ready low after write", d & 32'h80, 32'h0);
    bus_rd(8'h3C, d); chk("R5 key consumed", d, 32'h0);
    bus_rd(8'h34, d); chk("R2 scratch readback", d, 32'h0000_CAFE);
    wait_rdy();
    bus_wr(8'h34, 32'h5);
    bus_rd(8'h34, d); chk("R5 one write per key", d, 32'h0000_CAFE);
    bus_rd(8'h10, d); chk("R2 unmapped reads zero", d, 32'h0);

    uwr(8'h08, 32'hFFFF_FFFF);
    uwr(8'h04, 32'hFFFF_FFFE);
    bus_rd(8'h04, d); chk("R2 sec readback", d, 32'hFFFF_FFFE);
    bus_rd(8'h08, d); chk("R2 alarm readback", d, 32'hFFFF_FFFF);

    uwr(8'h00, 32'h7D);
    for (int i = 0; i < 200 && m_sec != 32'h0; i++) @(negedge clk);
    bus_rd(8'h04, d); chk("R3 wrap to zero", d, 32'h0);
    bus_rd(8'h00, d); chk("R6 both flags set", d & 32'h50, 32'h50);
    @(negedge clk);
    chk("R8 irq asserted", {31'h0, irq_o}, 32'h1);

    uwr(8'h00, 32'h38);
    bus_rd(8'h00, d);
    chk("R7 alarm flag kept by writing 1", d & 32'h10, 32'h10);
    chk("R7 hz flag cleared by writing 0", (d >> 6) & 32'h1, {31'h0, m_hzf});
    chk("R3 counter disabled", d & 32'h1, 32'h0);

    uwr(8'h00, 32'h68);
    bus_rd(8'h00, d); chk("R7 alarm flag cleared", d & 32'h10, 32'h0);
    repeat (2) @(negedge clk);
    chk("R8 irq follows masked flags", {31'h0, irq_o}, {31'h0, m_hzf});

    bus_rd(8'h04, d);
    repeat (40) @(negedge clk);
    bus_rd(8'h04, d2); chk("R3 count holds while disabled", d2, d);

    uwr(8'h00, 32'h71);
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < 100 && !(m_pre == 0 && !slow); i++) @(negedge clk);
      bus_rd(8'h04, d);
      bus_rd(8'h04, d2);
      chk("R9 consecutive reads agree", d2, d);
      repeat (7) @(negedge clk);
    end
    bus_rd(8'h04, d); chk("R3 count advanced", d, m_sec);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule